// File: doc/BRIEF.md
# Dual-Lane Scannable Bus Transceiver Core

This block carries two independent 9-bit lanes of non-inverting, bidirectional buffering between an A side and a B side. Each lane has its own active-low lane enable and its own direction input. Every pin is modelled as separate input, output and output-enable signals rather than as tri-state nets. When the direction input is 1, a lane drives the A-side input value out on the B side. When it is 0, the lane drives the B-side value out on the A side. While the lane enable is high, neither side of that lane drives.

A boundary-scan register of 80 cells surrounds both lanes. Observe-only cells sit on every pin input, including each lane enable and each direction input. Observe-and-control cells sit on every pin output and on the two internal active-high output enables of each lane: one enable for the A side and one for the B side. Each control cell has a shift stage and an update latch. When test mode is selected, every output and every output enable comes from its update latch instead of from the system logic.

The scan port has one serial input and one serial output, plus capture, shift and update strobes. Each strobe acts on the rising edge of the block clock. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `dual_byte_bscan_xcvr`

## Requirements
- R1: In normal mode (test_mode=0), a lane with lane_oe_n=0 and lane_a2b=1 drives b_out equal to its a_in, with b_oe=1 and a_oe=0.
- R2: In normal mode, a lane with lane_oe_n=0 and lane_a2b=0 drives a_out equal to its b_in, with a_oe=1 and b_oe=0.
- R3: In normal mode, a lane with lane_oe_n=1 has a_oe=0 and b_oe=0, whatever the value of lane_a2b.
- R4: The two lanes are independent. Lane k uses bits [9k+8:9k] of the data ports and bit k of the enable and direction ports.
- R5: The chain is 80 cells long. A 1 presented on scan_in before the first of a run of shift clocks appears on scan_out after exactly 80 rising edges with shift_dr=1.
- R6: Cell layout for lane k, with base 36k:
  - cells base+0..8 hold a_in;
  - cells base+9..17 hold the a_out drive;
  - cells base+18..26 hold b_in;
  - cells base+27..35 hold the b_out drive.
- R6 (continued): Bit i of a group sits at base + group offset + i. Cells 72+4k, 73+4k, 74+4k and 75+4k hold a_oe, b_oe, lane_oe_n and lane_a2b of lane k. scan_in feeds cell 0, and scan_out is cell 79. A capture_dr edge loads every cell with its current value.
- R7: Update latches change only on a rising edge with update_dr=1. Shifting alone leaves every test-mode output unchanged.
- R8: In test mode, each output and output enable equals its update latch. Enable latch value 1 turns that side's outputs on and 0 turns them off, independent of lane_oe_n and lane_a2b.
- R9: In normal mode, the update latches have no effect on any output. a_out always equals b_in and b_out always equals a_in.
- R10: After reset, every shift stage and update latch is 0. scan_out is 0, and test mode then drives every output and enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_oe_n | input | 2 | Per-lane active-low enable |
| lane_a2b | input | 2 | Per-lane direction, 1 = A to B |
| a_in | input | 18 | A-side pin inputs, lane k at [9k+8:9k] |
| b_in | input | 18 | B-side pin inputs |
| a_out | output | 18 | A-side pin outputs |
| a_oe | output | 2 | Per-lane A-side output enable |
| b_out | output | 18 | B-side pin outputs |
| b_oe | output | 2 | Per-lane B-side output enable |
| test_mode | input | 1 | Selects update latches onto outputs |
| shift_dr | input | 1 | Shift the chain one cell per edge |
| capture_dr | input | 1 | Load cells from their observed values |
| update_dr | input | 1 | Copy shift stages into update latches |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output |

## Verification
The bench walks every enable and direction combination in both lanes at once, using a different combination in each lane. A swapped direction decode would drive the wrong side, and a missing enable gate would drive a disabled lane. Capture is checked against the full 80-bit layout; a misplaced cell or a reversed chain shows up as a shifted or mirrored bit pattern. The bench times the chain to the exact edge, which catches a missing or extra cell.

In test mode the bench first shifts without updating, then updates, then toggles the lane pins. This exposes latches that load during shift, enables that still follow the pins, and a test mode that leaks into normal operation.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  // data cell groups inside one lane, in chain order
  localparam int unsigned GRP_A_OBS = 0;
  localparam int unsigned GRP_A_DRV = 1;
  localparam int unsigned GRP_B_OBS = 2;
  localparam int unsigned GRP_B_DRV = 3;
  localparam int unsigned GRPS      = 4;
  // control cells of one lane, in chain order
  localparam int unsigned CTL_A_EN  = 0;
  localparam int unsigned CTL_B_EN  = 1;
  localparam int unsigned CTL_OE_N  = 2;
  localparam int unsigned CTL_A2B   = 3;
  localparam int unsigned CTLS      = 4;
endpackage

// File: rtl/dbx_obs_cell.sv
module dbx_obs_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic si,
  input  logic pin,
  output logic so
);
  logic stage_q;
  logic stage_d;
  logic stage_en;

  always_comb begin
    stage_en = capture_en | shift_en;
    stage_d  = capture_en ? pin : si;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  assign so = stage_q;
endmodule

// File: rtl/dbx_ctl_cell.sv
module dbx_ctl_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic test_mode,
  input  logic si,
  input  logic sys_val,
  output logic so,
  output logic drive
);
  logic stage_q;
  logic stage_d;
  logic stage_en;
  logic latch_q;

  // the value placed on the pin: system logic or the update latch
  always_comb begin
    drive    = test_mode ? latch_q : sys_val;
    stage_en = capture_en | shift_en;
    stage_d  = capture_en ? drive : si;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (update_en) begin
      latch_q <= stage_q;
    end
  end

  assign so = stage_q;
endmodule

// File: rtl/dbx_lane.sv
module dbx_lane
  import dbx_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         capture_en,
  input  logic         update_en,
  input  logic         test_mode,
  input  logic         oe_n,
  input  logic         a2b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         data_si,
  output logic         data_so,
  input  logic         ctl_si,
  output logic         ctl_so
);
  localparam int unsigned DATA_CELLS = GRPS * W;

  logic [DATA_CELLS:0] dch;
  logic [CTLS:0]       cch;
  logic                a_oe_sys;
  logic                b_oe_sys;

  // internal active-high side enables decoded from the lane pins
  always_comb begin
    a_oe_sys = ~oe_n & ~a2b;
    b_oe_sys = ~oe_n &  a2b;
  end

  assign dch[0]  = data_si;
  assign data_so = dch[DATA_CELLS];
  assign cch[0]  = ctl_si;
  assign ctl_so  = cch[CTLS];

  for (genvar i = 0; i < W; i++) begin : g_bit
    dbx_obs_cell u_a_obs (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
      .si(dch[GRP_A_OBS*W+i]), .pin(a_in[i]), .so(dch[GRP_A_OBS*W+i+1])
    );
    dbx_ctl_cell u_a_drv (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
      .update_en(update_en), .test_mode(test_mode),
      .si(dch[GRP_A_DRV*W+i]), .sys_val(b_in[i]),
      .so(dch[GRP_A_DRV*W+i+1]), .drive(a_out[i])
    );
    dbx_obs_cell u_b_obs (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
      .si(dch[GRP_B_OBS*W+i]), .pin(b_in[i]), .so(dch[GRP_B_OBS*W+i+1])
    );
    dbx_ctl_cell u_b_drv (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
      .update_en(update_en), .test_mode(test_mode),
      .si(dch[GRP_B_DRV*W+i]), .sys_val(a_in[i]),
      .so(dch[GRP_B_DRV*W+i+1]), .drive(b_out[i])
    );
  end

  dbx_ctl_cell u_a_en (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
    .update_en(update_en), .test_mode(test_mode),
    .si(cch[CTL_A_EN]), .sys_val(a_oe_sys), .so(cch[CTL_A_EN+1]), .drive(a_oe)
  );
  dbx_ctl_cell u_b_en (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
    .update_en(update_en), .test_mode(test_mode),
    .si(cch[CTL_B_EN]), .sys_val(b_oe_sys), .so(cch[CTL_B_EN+1]), .drive(b_oe)
  );
  dbx_obs_cell u_oe_obs (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
    .si(cch[CTL_OE_N]), .pin(oe_n), .so(cch[CTL_OE_N+1])
  );
  dbx_obs_cell u_dir_obs (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture_en(capture_en),
    .si(cch[CTL_A2B]), .pin(a2b), .so(cch[CTL_A2B+1])
  );
endmodule

// File: rtl/dual_byte_bscan_xcvr.sv
module dual_byte_bscan_xcvr
  import dbx_pkg::*;
#(
  parameter int unsigned LANE_W  = 9,
  parameter int unsigned N_LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LANES-1:0]        lane_oe_n,
  input  logic [N_LANES-1:0]        lane_a2b,
  input  logic [N_LANES*LANE_W-1:0] a_in,
  input  logic [N_LANES*LANE_W-1:0] b_in,
  output logic [N_LANES*LANE_W-1:0] a_out,
  output logic [N_LANES-1:0]        a_oe,
  output logic [N_LANES*LANE_W-1:0] b_out,
  output logic [N_LANES-1:0]        b_oe,
  input  logic                      test_mode,
  input  logic                      shift_dr,
  input  logic                      capture_dr,
  input  logic                      update_dr,
  input  logic                      scan_in,
  output logic                      scan_out
);
  localparam int unsigned DATA_CELLS = GRPS * LANE_W;
  localparam int unsigned CHAIN_LEN  = N_LANES * (DATA_CELLS + CTLS);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_q;
  logic [N_LANES:0] data_link;
  logic [N_LANES:0] ctl_link;

  // reset asserts at once and is released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_q = rst_pipe_q[1];

  // chain: scan_in, all data segments, then all control segments
  assign data_link[0] = scan_in;
  assign ctl_link[0]  = data_link[N_LANES];
  assign scan_out     = ctl_link[N_LANES];

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    dbx_lane #(.W(LANE_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n_q),
      .shift_en  (shift_dr),
      .capture_en(capture_dr),
      .update_en (update_dr),
      .test_mode (test_mode),
      .oe_n      (lane_oe_n[l]),
      .a2b       (lane_a2b[l]),
      .a_in      (a_in[l*LANE_W +: LANE_W]),
      .b_in      (b_in[l*LANE_W +: LANE_W]),
      .a_out     (a_out[l*LANE_W +: LANE_W]),
      .a_oe      (a_oe[l]),
      .b_out     (b_out[l*LANE_W +: LANE_W]),
      .b_oe      (b_oe[l]),
      .data_si   (data_link[l]),
      .data_so   (data_link[l+1]),
      .ctl_si    (ctl_link[l]),
      .ctl_so    (ctl_link[l+1])
    );
  end

  initial begin
    if (CHAIN_LEN < 2) $error("chain too short");
  end
endmodule

// File: rtl/dbx_checker.sv
module dbx_checker #(
  parameter int unsigned LANE_W  = 9,
  parameter int unsigned N_LANES = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      test_mode,
  input logic                      update_dr,
  input logic [N_LANES-1:0]        lane_oe_n,
  input logic [N_LANES-1:0]        lane_a2b,
  input logic [N_LANES*LANE_W-1:0] a_in,
  input logic [N_LANES*LANE_W-1:0] b_in,
  input logic [N_LANES*LANE_W-1:0] a_out,
  input logic [N_LANES-1:0]        a_oe,
  input logic [N_LANES*LANE_W-1:0] b_out,
  input logic [N_LANES-1:0]        b_oe
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane_chk
    AST_A2B_ENABLES_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !lane_oe_n[l] && lane_a2b[l]) |-> (b_oe[l] && !a_oe[l])); // R1
    AST_B2A_ENABLES_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !lane_oe_n[l] && !lane_a2b[l]) |-> (a_oe[l] && !b_oe[l])); // R2
    AST_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && lane_oe_n[l]) |-> (!a_oe[l] && !b_oe[l])); // R3
  end

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> ((a_out == b_in) && (b_out == a_in))); // R9

  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && $past(test_mode) && !$past(update_dr)) |->
      $stable({a_out, b_out, a_oe, b_oe})); // R7
endmodule

bind dual_byte_bscan_xcvr dbx_checker #(.LANE_W(LANE_W), .N_LANES(N_LANES)) chk_i (
  .clk(clk), .rst_n(rst_n_q), .test_mode(test_mode), .update_dr(update_dr),
  .lane_oe_n(lane_oe_n), .lane_a2b(lane_a2b), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/dual_byte_bscan_xcvr_tb_top.sv
module dual_byte_bscan_xcvr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;
  localparam int NL = 2;
  localparam int N = 80;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] lane_oe_n, lane_a2b, a_oe, b_oe;
  logic [NL*W-1:0] a_in, b_in, a_out, b_out;
  logic test_mode, shift_dr, capture_dr, update_dr, scan_in, scan_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_byte_bscan_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .lane_oe_n(lane_oe_n), .lane_a2b(lane_a2b),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out),
    .b_oe(b_oe), .test_mode(test_mode), .shift_dr(shift_dr),
    .capture_dr(capture_dr), .update_dr(update_dr), .scan_in(scan_in),
    .scan_out(scan_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // expected chain image from the cell layout of R6
  function automatic logic [N-1:0] cells(
      input logic [NL*W-1:0] ain, aout, bin, bout,
      input logic [NL-1:0] aoe, boe, oen, a2b);
    logic [N-1:0] v = '0;
    for (int l = 0; l < NL; l++) begin
      for (int i = 0; i < W; i++) begin
        v[l*36 + i]      = ain[l*W+i];
        v[l*36 + 9 + i]  = aout[l*W+i];
        v[l*36 + 18 + i] = bin[l*W+i];
        v[l*36 + 27 + i] = bout[l*W+i];
      end
      v[72 + 4*l] = aoe[l];
      v[73 + 4*l] = boe[l];
      v[74 + 4*l] = oen[l];
      v[75 + 4*l] = a2b[l];
    end
    return v;
  endfunction

  task automatic shift_vec(input logic [N-1:0] vin, output logic [N-1:0] vout);
    for (int s = 0; s < N; s++) begin
      @(negedge clk);
      vout[N-1-s] = scan_out;
      scan_in  = vin[N-1-s];
      shift_dr = 1'b1;
    end
    @(negedge clk);
    shift_dr = 1'b0;
    scan_in  = 1'b0;
  endtask

  task automatic pulse_capture();
    @(negedge clk); capture_dr = 1'b1;
    @(negedge clk); capture_dr = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_dr = 1'b1;
    @(negedge clk); update_dr = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lane_oe_n = '1; lane_a2b = '0; a_in = '0; b_in = '0;
    test_mode = 0; shift_dr = 0; capture_dr = 0; update_dr = 0; scan_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 scan_out", N'(scan_out), '0);
    chk("R10 oe off", N'({a_oe, b_oe}), '0);
    test_mode = 1'b1; lane_oe_n = 2'b00; lane_a2b = 2'b01;
    a_in = 18'h3FFFF; b_in = 18'h3FFFF;
    #1;
    chk("R10 test outputs", N'({a_out, b_out, a_oe, b_oe}), '0);
    test_mode = 1'b0;
  endtask

  task automatic t_normal();
    for (int c = 0; c < 4; c++) begin
      logic [NL-1:0] eoe, ebe;
      @(negedge clk);
      lane_oe_n = {c[0], c[1]};
      lane_a2b  = {~c[1], c[0]};
      a_in = 18'h2A5C3 ^ (18'h1111 * c);
      b_in = 18'h15A3C ^ (18'h0F0F * c);
      #1;
      for (int l = 0; l < NL; l++) begin
        eoe[l] = !lane_oe_n[l] && !lane_a2b[l];
        ebe[l] = !lane_oe_n[l] && lane_a2b[l];
      end
      chk("R1 R2 R3 R4 a_oe", N'(a_oe), N'(eoe));
      chk("R1 R2 R3 R4 b_oe", N'(b_oe), N'(ebe));
      chk("R1 b_out data", N'(b_out), N'(a_in));
      chk("R2 a_out data", N'(a_out), N'(b_in));
    end
  endtask

  task automatic t_chain_len();
    @(negedge clk);
    lane_oe_n = '1; lane_a2b = '0; a_in = '0; b_in = '0; test_mode = 0;
    pulse_capture();
    chk("R5 pre", N'(scan_out), '0);
    scan_in = 1'b1; shift_dr = 1'b1;
    @(negedge clk);
    scan_in = 1'b0;
    for (int k = 2; k <= N; k++) begin
      @(negedge clk);
      if (k == N - 1) chk("R5 edge 79", N'(scan_out), '0);
      if (k == N)     chk("R5 edge 80", N'(scan_out), 1);
    end
    shift_dr = 1'b0;
  endtask

  task automatic t_capture();
    logic [N-1:0] got;
    @(negedge clk);
    lane_oe_n = 2'b10; lane_a2b = 2'b01; test_mode = 0;
    a_in = 18'h1C96B; b_in = 18'h0A3D4;
    pulse_capture();
    shift_vec('0, got);
    chk("R6 capture image", got,
        cells(a_in, b_in, b_in, a_in, 2'b00, 2'b01, lane_oe_n, lane_a2b));
  endtask

  task automatic t_update();
    logic [N-1:0] got;
    logic [NL*W-1:0] apat, bpat;
    apat = 18'h0F3A5;
    bpat = 18'h2C3C3;
    @(negedge clk);
    test_mode = 1'b1; lane_oe_n = 2'b00; lane_a2b = 2'b00;
    shift_vec(cells('0, apat, '0, bpat, 2'b01, 2'b10, '0, '0), got);
    #1;
    chk("R7 no update yet", N'({a_out, b_out, a_oe, b_oe}), '0);
    pulse_update();
    chk("R8 a_out latch", N'(a_out), N'(apat));
    chk("R8 b_out latch", N'(b_out), N'(bpat));
    chk("R8 enable cells", N'({a_oe, b_oe}), N'({2'b01, 2'b10}));
    @(negedge clk);
    lane_oe_n = 2'b11; lane_a2b = 2'b11; a_in = '1; b_in = '1;
    #1;
    chk("R8 pins ignored", N'({a_out, b_out, a_oe, b_oe}), N'({apat, bpat, 2'b01, 2'b10}));
    shift_vec('0, got);
    #1;
    chk("R7 shift holds", N'({a_out, b_out, a_oe, b_oe}), N'({apat, bpat, 2'b01, 2'b10}));
    @(negedge clk);
    test_mode = 1'b0; lane_oe_n = 2'b01; lane_a2b = 2'b00;
    a_in = 18'h12345; b_in = 18'h2468A;
    #1;
    chk("R9 normal again", N'({a_out, b_out, a_oe, b_oe}),
        N'({18'h2468A, 18'h12345, 2'b10, 2'b00}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_chain_len();
    t_capture();
    t_update();
    done = 1;
    summary();
    $finish;
  end
endmodule